// File: doc/BRIEF.md
# Synchronous Burst-Read Sequencer

This block is the device-side control logic of a flash-style memory that serves reads over an external bus. The bus master supplies a bus clock, a chip enable, an address-valid strobe and an address. The block keeps a 16-bit configuration word. When synchronous mode is selected, the block latches a start address on an active bus-clock edge. It counts a programmable first-access latency and then streams array words from consecutive addresses onto the data bus. The word array sits outside the block and is reached through a combinational address/data lookup. A single pin serves two purposes. In wait mode it is an output that marks data as not yet valid. In ready mode it is an input, and a high-low-high pulse on it restarts the address-latch sequence.

All logic runs on one rising-edge system clock. The bus clock is sampled as data, and the edge selected by the configuration word becomes a one-cycle clock enable. Configuration writes arrive through a dedicated strobe. Burst parameters are copied from the configuration word only when an address is latched, so a write has no effect on a burst that is already running. In asynchronous mode the data bus follows the array word at the input address, with no strobe and no latency.

Top module: `burst_read_seq`

## Requirements
- R1: Out of reset the configuration word is 0x28D0: synchronous reads, latency code 5, rising active edge, sequential bursts, ready-pin mode, one-edge hold, wait flagged during the wait state, active-low wait. After reset `dq_o` is 0 and `rw_oe_o` is 0.
- R2: Bits 13..11 hold the latency code L; codes 0 and 1 act as 2. The address is latched on an active edge with `ce_i` and `adv_i` high. `dq_o` shows 0 from that edge onward and first shows the word at the start address on the L-th active edge after the latch edge.
- R3: Each following word comes from the previous address plus one, wrapping modulo 2^AW. Bit 7 (burst order) has no effect on the sequence.
- R4: When bit 9 is 1, each word stays on `dq_o` for two consecutive active edges. When bit 9 is 0, a new word appears on every active edge.
- R5: When bit 4 is 0 (wait-pin mode), `rw_oe_o` is 1 from the latch edge until the burst ends. With bit 8 at 0, wait is asserted after the latch edge and after each following edge up to edge L-1. Wait is negated from edge L onward.
- R6: With bit 8 at 1, wait is negated one active edge earlier: it is asserted only up to edge L-2.
- R7: Bit 10 selects the pin level of an asserted wait: 0 drives 0 and 1 drives 1. A negated wait drives the opposite level. When bit 4 is 1, `rw_oe_o` stays 0 whatever bit 10 holds.
- R8: Bit 6 selects the active bus-clock edge: 1 selects rising and 0 selects falling. Bus-clock transitions of the other direction leave `dq_o` and the sequencer unchanged.
- R9: When bit 15 is 1 and `ce_i` is high, `dq_o` equals the array word at `addr_i` one system clock later. No strobe or latency is involved.
- R10: A system clock edge with `ce_i` low ends any burst: afterwards `dq_o` is 0 and `rw_oe_o` is 0.
- R11: A configuration write during a burst leaves that burst's latency, hold, wait timing and polarity unchanged. The written values apply from the next address latch.
- R12: In ready-pin mode, a low pulse on `rw_in_i` (high, low, high) makes the next active edge with `ce_i` high latch `addr_i` as a burst start without `adv_i`. Without that pulse or `adv_i`, no burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| kclk_i | input | 1 | Bus clock, sampled as data in the `clk` domain |
| ce_i | input | 1 | Chip enable, active high |
| adv_i | input | 1 | Address-valid strobe |
| addr_i | input | AW | Burst start address / asynchronous read address |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| arr_addr_o | output | AW | Address presented to the word array |
| arr_data_i | input | DW | Word returned by the array for `arr_addr_o` |
| dq_o | output | DW | Data bus |
| rw_in_i | input | 1 | Ready/wait pin as seen at the input |
| rw_out_o | output | 1 | Ready/wait pin drive level |
| rw_oe_o | output | 1 | Ready/wait pin drive enable |

## Verification
Synchronous results change on the system clock edge that sees the selected bus-clock transition. The bench toggles the bus clock on a falling system-clock edge and samples on the next falling edge, so every expected value is compared exactly one system clock after the transition that causes it. Latency and hold are counted in active edges by the bench's own loop. Each data check therefore lands on a known edge index: 0 before edge L, the start word on edge L, then one new word per edge or per two edges. Asynchronous reads, chip-enable release and the pin pulse are applied between bus-clock edges and compared one system clock later.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h28D0;

  localparam int B_ASYNC  = 15;
  localparam int B_LAT_HI = 13;
  localparam int B_LAT_LO = 11;
  localparam int B_POL    = 10;
  localparam int B_HOLD   = 9;
  localparam int B_EARLY  = 8;
  localparam int B_RISE   = 6;
  localparam int B_READY  = 4;

  localparam int LAT_W = B_LAT_HI - B_LAT_LO + 1;
  localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(2);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic             async_rd;
    logic [LAT_W-1:0] lat;
    logic             wait_hi;
    logic             hold2;
    logic             wait_early;
    logic             rise_edge;
    logic             ready_mode;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] raw);
    cfg_t c;
    c.async_rd   = raw[B_ASYNC];
    c.lat        = raw[B_LAT_HI:B_LAT_LO];
    c.wait_hi    = raw[B_POL];
    c.hold2      = raw[B_HOLD];
    c.wait_early = raw[B_EARLY];
    c.rise_edge  = raw[B_RISE];
    c.ready_mode = raw[B_READY];
    return c;
  endfunction

  function automatic logic [LAT_W-1:0] lat_clamp(input logic [LAT_W-1:0] code);
    return (code < LAT_MIN) ? LAT_MIN : code;
  endfunction

endpackage

// File: rtl/bsr_cfg_reg.sv
module bsr_cfg_reg
  import bsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);

  cfg_t cfg_q;

  // Only decoded fields are stored; the remaining bits are don't-care.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_decode(CFG_RESET);
    end else if (we_i) begin
      cfg_q <= cfg_decode(wdata_i);
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wdata_i[14], wdata_i[7], wdata_i[5], wdata_i[3:0]};

  assign cfg_o = cfg_q;

endmodule

// File: rtl/bsr_edge_sel.sv
module bsr_edge_sel (
  input  logic clk,
  input  logic rst,
  input  logic kclk_i,
  input  logic rise_i,
  output logic tick_o
);

  logic kclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      kclk_d <= 1'b0;
    end else begin
      kclk_d <= kclk_i;
    end
  end

  // One-cycle enable on the selected bus-clock transition.
  assign tick_o = rise_i ? (kclk_i & ~kclk_d) : (~kclk_i & kclk_d);

endmodule

// File: rtl/bsr_relatch_det.sv
module bsr_relatch_det (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic pin_i,
  input  logic consume_i,
  output logic pend_o
);

  logic pin_d;
  logic armed;
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_d <= 1'b0;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pin_d <= pin_i;
      if (!enable_i) begin
        armed <= 1'b0;
        pend  <= 1'b0;
      end else begin
        if (pin_d && !pin_i) begin
          armed <= 1'b1;
        end else if (armed && !pin_d && pin_i) begin
          armed <= 1'b0;
        end
        if (consume_i) begin
          pend <= 1'b0;
        end else if (armed && !pin_d && pin_i) begin
          pend <= 1'b1;
        end
      end
    end
  end

  assign pend_o = pend;

endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
  import bsr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg_i,
  input  logic          tick_i,
  input  logic          ce_i,
  input  logic          adv_i,
  input  logic          relatch_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [AW-1:0] arr_addr_o,
  output logic [DW-1:0] dq_o,
  output logic          rw_out_o,
  output logic          rw_oe_o,
  output logic          latch_o
);

  seq_st_e          st;
  logic [LAT_W-1:0] cnt;
  logic [AW-1:0]    cur;
  logic             ph;
  logic [DW-1:0]    dq;
  logic             wait_act;
  cfg_t             snap;

  assign latch_o    = ce_i && !cfg_i.async_rd && tick_i && (adv_i || relatch_i);
  assign arr_addr_o = cfg_i.async_rd ? addr_i : cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cur      <= '0;
      ph       <= 1'b0;
      dq       <= '0;
      wait_act <= 1'b0;
      snap     <= cfg_decode(CFG_RESET);
    end else if (!ce_i) begin
      st       <= ST_IDLE;
      dq       <= '0;
      wait_act <= 1'b0;
      ph       <= 1'b0;
    end else if (cfg_i.async_rd) begin
      st       <= ST_IDLE;
      dq       <= arr_data_i;
      wait_act <= 1'b0;
    end else if (latch_o) begin
      st       <= ST_LAT;
      cnt      <= lat_clamp(cfg_i.lat);
      cur      <= addr_i;
      dq       <= '0;
      wait_act <= 1'b1;
      ph       <= 1'b0;
      snap     <= cfg_i;
    end else if (tick_i) begin
      case (st)
        ST_LAT: begin
          if (cnt == LAT_W'(1)) begin
            st       <= ST_DATA;
            dq       <= arr_data_i;
            cur      <= cur + AW'(1);
            ph       <= 1'b0;
            wait_act <= 1'b0;
          end else begin
            cnt      <= cnt - LAT_W'(1);
            wait_act <= snap.wait_early ? (cnt > LAT_W'(2)) : 1'b1;
          end
        end
        ST_DATA: begin
          if (snap.hold2 && !ph) begin
            ph <= 1'b1;
          end else begin
            dq  <= arr_data_i;
            cur <= cur + AW'(1);
            ph  <= 1'b0;
          end
        end
        default: begin
          st <= ST_IDLE;
        end
      endcase
    end
  end

  assign dq_o     = dq;
  assign rw_oe_o  = (st != ST_IDLE) && !snap.ready_mode;
  assign rw_out_o = snap.wait_hi ? wait_act : ~wait_act;

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bsr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kclk_i,
  input  logic             ce_i,
  input  logic             adv_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [AW-1:0]    arr_addr_o,
  input  logic [DW-1:0]    arr_data_i,
  output logic [DW-1:0]    dq_o,
  input  logic             rw_in_i,
  output logic             rw_out_o,
  output logic             rw_oe_o
);

  cfg_t cfg_live;
  logic tick;
  logic relatch_pend;
  logic latch;
  logic async_live;

  assign async_live = cfg_live.async_rd;

  bsr_cfg_reg cfg_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_live)
  );

  bsr_edge_sel edge_i (
    .clk    (clk),
    .rst    (rst),
    .kclk_i (kclk_i),
    .rise_i (cfg_live.rise_edge),
    .tick_o (tick)
  );

  bsr_relatch_det relatch_i (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (cfg_live.ready_mode),
    .pin_i     (rw_in_i),
    .consume_i (latch),
    .pend_o    (relatch_pend)
  );

  bsr_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_i      (cfg_live),
    .tick_i     (tick),
    .ce_i       (ce_i),
    .adv_i      (adv_i),
    .relatch_i  (relatch_pend),
    .addr_i     (addr_i),
    .arr_data_i (arr_data_i),
    .arr_addr_o (arr_addr_o),
    .dq_o       (dq_o),
    .rw_out_o   (rw_out_o),
    .rw_oe_o    (rw_oe_o),
    .latch_o    (latch)
  );

endmodule

// File: rtl/bsr_chk.sv
module bsr_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_i,
  input logic          tick,
  input logic          async_live,
  input logic [DW-1:0] arr_data_i,
  input logic [DW-1:0] dq_o,
  input logic          rw_oe_o
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> (dq_o == '0 && !rw_oe_o));

  assert_dq_only_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (ce_i && !async_live && !tick) |=> $stable(dq_o));

  assert_oe_needs_ce_R5: assert property (@(posedge clk) disable iff (rst)
    rw_oe_o |-> $past(ce_i));

  assert_async_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (ce_i && async_live) |=> (dq_o == $past(arr_data_i)));

  assert_ce_low_ends_R10: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> (dq_o == '0 && !rw_oe_o));

endmodule

bind burst_read_seq bsr_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ce_i       (ce_i),
  .tick       (tick),
  .async_live (async_live),
  .arr_data_i (arr_data_i),
  .dq_o       (dq_o),
  .rw_oe_o    (rw_oe_o)
);

// File: tb/burst_read_seq_tb_top.sv
module burst_read_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          kclk = 1'b0;
  logic          ce = 1'b0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] dq;
  logic          rw_in = 1'b1;
  logic          rw_out;
  logic          rw_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] arr_f(input logic [AW-1:0] a);
    logic [31:0] t;
    t = {20'd0, a} * 32'd40503;
    return (t[DW-1:0] ^ 16'hA5C3) | 16'h0001;
  endfunction

  assign arr_data = arr_f(arr_addr);

  burst_read_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .kclk_i(kclk), .ce_i(ce), .adv_i(adv), .addr_i(addr),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .arr_addr_o(arr_addr),
    .arr_data_i(arr_data), .dq_o(dq), .rw_in_i(rw_in), .rw_out_o(rw_out), .rw_oe_o(rw_oe)
  );

  function automatic logic [15:0] mkcfg(input int lat, input bit hold, input bit early,
                                        input bit pol, input bit ready, input bit rise,
                                        input bit b7);
    logic [15:0] c;
    c = '0;
    c[13:11] = lat[2:0];
    c[10] = pol; c[9] = hold; c[8] = early; c[7] = b7; c[6] = rise; c[4] = ready;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wcfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic half();
    @(negedge clk); kclk = ~kclk;
    @(negedge clk);
  endtask

  task automatic aedge(input bit rise);
    do half(); while (kclk != rise);
  endtask

  task automatic chk_pin(input bit ready, input bit early, input bit pol, input bit act);
    if (ready) chk("R7 ready pin undriven", rw_oe, 0);
    else begin
      chk("R5 wait pin driven", rw_oe, 1);
      chk(early ? "R6/R7 wait level" : "R5/R7 wait level", rw_out, pol ? act : !act);
    end
  endtask

  task automatic burst(input logic [AW-1:0] a, input logic [15:0] c, input int n,
                       input bit wr, input bit relatch, input bit midwr, input logic [15:0] midv);
    int L; bit hold, early, pol, ready, rise;
    L = (c[13:11] < 2) ? 2 : int'(c[13:11]);
    hold = c[9]; early = c[8]; pol = c[10]; ready = c[4]; rise = c[6];
    if (wr) wcfg(c);
    @(negedge clk); ce = 1'b1; addr = a;
    if (relatch) begin
      rw_in = 1'b0; @(negedge clk); @(negedge clk);
      rw_in = 1'b1; @(negedge clk);
    end else adv = 1'b1;
    aedge(rise);
    adv = 1'b0;
    chk("R2 zero at latch", dq, 0);
    chk_pin(ready, early, pol, 1'b1);
    if (midwr) wcfg(midv);
    for (int k = 1; k < L; k++) begin
      aedge(rise);
      chk("R2 zero during latency", dq, 0);
      chk_pin(ready, early, pol, early ? (k <= L-2) : 1'b1);
    end
    for (int w = 0; w < n; w++) begin
      for (int r = 0; r < (hold ? 2 : 1); r++) begin
        if (w == 0 && r == 0) begin
          half();
          chk("R8 other edge ignored", dq, 0);
          half();
        end else aedge(rise);
        chk((w == 0) ? "R2 first word" : (r == 1) ? "R4 held word" : "R3 next word",
            dq, arr_f(a + AW'(w)));
        chk_pin(ready, early, pol, 1'b0);
      end
    end
    @(negedge clk); ce = 1'b0;
    @(negedge clk);
    chk("R10 dq cleared", dq, 0);
    chk("R10 pin released", rw_oe, 0);
  endtask

  initial begin
    logic [15:0] c1, c2;
    int unsigned s;
    s = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dq after reset", dq, 0);
    chk("R1 pin after reset", rw_oe, 0);
    // R1: default configuration without any write
    burst(12'h100, 16'h28D0, 3, 0, 0, 0, 16'h0);
    // R2/R3: latency clamp and address wrap
    burst(12'hFFE, mkcfg(0, 0, 0, 0, 0, 1, 1), 4, 1, 0, 0, 16'h0);
    burst(12'h010, mkcfg(1, 1, 1, 1, 0, 1, 0), 3, 1, 0, 0, 16'h0);
    // R4/R6/R7/R8: falling edge, hold, early wait, active high
    burst(12'h3A5, mkcfg(4, 1, 1, 1, 0, 0, 1), 3, 1, 0, 0, 16'h0);
    burst(12'h777, mkcfg(7, 0, 0, 0, 0, 0, 0), 2, 1, 0, 0, 16'h0);
    // R11: write mid-burst, new values only for the next burst
    c1 = mkcfg(3, 0, 0, 1, 0, 1, 1);
    c2 = mkcfg(6, 1, 1, 0, 0, 1, 1);
    burst(12'h055, c1, 3, 1, 0, 1, c2);
    burst(12'h066, c2, 2, 0, 0, 0, 16'h0);
    // R12: no strobe, no pulse -> no burst
    wcfg(mkcfg(3, 0, 0, 0, 1, 1, 1));
    @(negedge clk); ce = 1'b1; addr = 12'h222;
    for (int k = 0; k < 5; k++) aedge(1'b1);
    chk("R12 no latch without pulse", dq, 0);
    @(negedge clk); ce = 1'b0;
    // R12: pin pulse relatches
    burst(12'h234, mkcfg(3, 0, 0, 0, 1, 1, 1), 3, 1, 1, 0, 16'h0);
    // R9: asynchronous reads
    wcfg(16'h8000 | mkcfg(3, 0, 0, 0, 1, 1, 1));
    @(negedge clk); ce = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] aa;
      aa = AW'($urandom);
      addr = aa;
      @(negedge clk);
      chk("R9 async word", dq, arr_f(aa));
    end
    ce = 1'b0;
    @(negedge clk);
    chk("R10 async released", dq, 0);
    // random bursts
    for (int i = 0; i < 14; i++) begin
      logic [15:0] c;
      c = mkcfg(int'($urandom % 8), $urandom % 2, $urandom % 2, $urandom % 2,
                $urandom % 2, $urandom % 2, $urandom % 2);
      c[14] = $urandom % 2; c[0] = $urandom % 2;
      burst(AW'($urandom), c, 1 + int'($urandom % 4), 1, 0, 0, 16'h0);
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule